// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block shapes the SCL clock of an I2C master. It runs on a reference clock and holds two pairs of phase counts, one for Standard-mode and one for Fast-mode, with a mode input that picks the pair. Its only action on the line is an open-drain pull: a drive-low output that the pad turns into a low level. When that output is not asserted the line is left to the pull-up.

A low phase begins in the cycle the block starts to pull. It runs for a fixed number of reference cycles and does not wait to see the line actually fall. A slow fall time therefore shortens the low time seen on the wire.

After the pull is released, the block watches the line. The line passes through a two-flop synchronizer and then a two-sample agreement filter. The high count starts only once the line reads high, so a slave that holds SCL low lengthens the high phase. The very first high phase after enabling skips this wait, because the line is already idle-high.

Two flags tell the surrounding sequencer whether the clock is in its high or its low phase, so it knows when it may move SDA.

Top module: `scl_wave_gen`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `en_i` low, `scl_drive_low_o`, `high_phase_o` and `low_phase_o` are all 0. Count and mode changes made while disabled have no visible effect.
- R2: The first clock edge that samples `en_i` high while the block is disabled starts a high phase: `high_phase_o` rises after that edge. `scl_drive_low_o` rises exactly selected-high-count + 3 cycles later.
- R3: A low phase keeps `scl_drive_low_o` and `low_phase_o` at 1 for exactly selected-low-count + 1 cycles. This holds for a count of 0, and whatever `scl_i` does.
- R4: With `scl_i` following the line (high once released), every high phase that follows a low phase lasts selected-high-count + 8 cycles.
- R5: If `scl_i` stays low for S cycles after the block releases the line, that high phase lasts selected-high-count + 8 + S cycles.
- R6: `mode_i` = 0 selects the Standard-mode pair (`std_hcnt_i`, `std_lcnt_i`). `mode_i` = 1 selects the Fast-mode pair (`fast_hcnt_i`, `fast_lcnt_i`).
- R7: The mode and the count are sampled on the clock edge that begins a phase. Changes during a phase take effect from the next phase of that kind.
- R8: `high_phase_o` is 1 exactly while enabled and released, and `low_phase_o` equals `scl_drive_low_o`. The two flags are never both 1.
- R9: Dropping `en_i` in any phase releases the line and clears both flags on the next edge. Raising it again restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| mode_i | input | 1 | Count pair select: 0 Standard, 1 Fast |
| std_hcnt_i | input | CNT_W | Standard-mode high count |
| std_lcnt_i | input | CNT_W | Standard-mode low count |
| fast_hcnt_i | input | CNT_W | Fast-mode high count |
| fast_lcnt_i | input | CNT_W | Fast-mode low count |
| scl_i | input | 1 | Sampled SCL line level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| high_phase_o | output | 1 | Clock is in its high phase |
| low_phase_o | output | 1 | Clock is in its low phase |

## Verification
Every output comes straight from the phase register, so a decision taken at one rising edge is visible right after that edge:
- The flags follow enable with a delay of one edge.
- The pull starts high-count + 3 edges after an enable.
- The pull ends low-count + 1 edges after it began.
- It returns high-count + 8 + S edges after a release.

The bench advances a behavioural phase model with remaining-cycle counters at each rising edge, feeding it the same inputs the design sampled. It then compares all three outputs at the following falling edge, so every check lands one half period after the edge that is due to change them.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_COUNT = 2'd2,
    PH_LOW   = 2'd3
  } scl_phase_e;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FAST = 1'b1
  } scl_mode_e;

  localparam int NUM_MODES = 2;

endpackage

// File: rtl/scl_in_filter.sv
module scl_in_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic line_i,
  output logic seen_high_o
);
  localparam int DEPTH = SYNC_STAGES + FILT_STAGES;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  // stage 0 takes the raw line; later stages shift; flush empties all
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign pipe_d[g] = flush_i ? 1'b0 : line_i;
      end else begin : g_tail
        assign pipe_d[g] = flush_i ? 1'b0 : pipe_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  // high only when every filter sample agrees on a high level
  assign seen_high_o = &pipe_q[DEPTH-1:SYNC_STAGES];

  AST_FLUSH_HIDES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !seen_high_o); // R5

endmodule

// File: rtl/scl_count_sel.sv
module scl_count_sel #(
  parameter int CNT_W = 16
) (
  input  logic             mode_i,
  input  logic [CNT_W-1:0] std_hcnt_i,
  input  logic [CNT_W-1:0] std_lcnt_i,
  input  logic [CNT_W-1:0] fast_hcnt_i,
  input  logic [CNT_W-1:0] fast_lcnt_i,
  output logic [CNT_W-1:0] hcnt_o,
  output logic [CNT_W-1:0] lcnt_o
);
  import scl_gen_pkg::*;

  logic [NUM_MODES-1:0][CNT_W-1:0] hbank;
  logic [NUM_MODES-1:0][CNT_W-1:0] lbank;

  // index by mode encoding: 0 standard, 1 fast
  assign hbank = {fast_hcnt_i, std_hcnt_i};
  assign lbank = {fast_lcnt_i, std_lcnt_i};

  always_comb begin
    hcnt_o = hbank[mode_i];
    lcnt_o = lbank[mode_i];
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
  parameter int CNT_W      = 16,
  parameter int HOLD_EXTRA = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic [CNT_W-1:0]         hcnt_i,
  input  logic [CNT_W-1:0]         lcnt_i,
  input  logic                     seen_high_i,
  output scl_gen_pkg::scl_phase_e  phase_o
);
  import scl_gen_pkg::*;

  localparam int CW    = CNT_W + 2;
  localparam int HLOAD = HOLD_EXTRA - 1;

  scl_phase_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_we;
  logic [CW-1:0] high_load;
  logic [CW-1:0] low_load;

  assign high_load = {{(CW-CNT_W){1'b0}}, hcnt_i} + CW'(HLOAD);
  assign low_load  = {{(CW-CNT_W){1'b0}}, lcnt_i};

  // next-state and counter logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_we = 1'b0;
    if (!en_i) begin
      st_d   = PH_IDLE;
      cnt_d  = '0;
      cnt_we = 1'b1;
    end else begin
      unique case (st_q)
        PH_IDLE: begin
          // line is idle-high: count at once
          st_d   = PH_COUNT;
          cnt_d  = high_load;
          cnt_we = 1'b1;
        end
        PH_WAIT: begin
          // count held until the filtered line reads high
          if (seen_high_i) begin
            st_d = PH_COUNT;
          end
        end
        PH_COUNT: begin
          cnt_we = 1'b1;
          if (cnt_q == '0) begin
            st_d  = PH_LOW;
            cnt_d = low_load;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        PH_LOW: begin
          cnt_we = 1'b1;
          if (cnt_q == '0) begin
            st_d  = PH_WAIT;
            cnt_d = high_load;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        default: begin
          st_d   = PH_IDLE;
          cnt_d  = '0;
          cnt_we = 1'b1;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = st_q;

  AST_START_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_IDLE && en_i) |=> (st_q == PH_COUNT)); // R2

  AST_LOW_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_LOW && cnt_q != '0 && en_i) |=>
      (st_q == PH_LOW && cnt_q == $past(cnt_q) - CW'(1))); // R3

  AST_LOW_ENDS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_LOW && cnt_q == '0 && en_i) |=> (st_q == PH_WAIT)); // R4

  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_WAIT && !seen_high_i && en_i) |=>
      (st_q == PH_WAIT && $stable(cnt_q))); // R5

  AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == PH_IDLE)); // R9

endmodule

// File: rtl/scl_wave_gen.sv
module scl_wave_gen #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_STAGES = 2,
  parameter int HOLD_EXTRA  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] std_hcnt_i,
  input  logic [CNT_W-1:0] std_lcnt_i,
  input  logic [CNT_W-1:0] fast_hcnt_i,
  input  logic [CNT_W-1:0] fast_lcnt_i,
  input  logic             scl_i,
  output logic             scl_drive_low_o,
  output logic             high_phase_o,
  output logic             low_phase_o
);
  import scl_gen_pkg::*;

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;
  logic [CNT_W-1:0]      hcnt_sel;
  logic [CNT_W-1:0]      lcnt_sel;
  logic                  seen_high;
  logic                  flush;
  scl_phase_e            phase;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  scl_count_sel #(
    .CNT_W (CNT_W)
  ) u_sel (
    .mode_i      (mode_i),
    .std_hcnt_i  (std_hcnt_i),
    .std_lcnt_i  (std_lcnt_i),
    .fast_hcnt_i (fast_hcnt_i),
    .fast_lcnt_i (fast_lcnt_i),
    .hcnt_o      (hcnt_sel),
    .lcnt_o      (lcnt_sel)
  );

  // the line is ours while pulling: discard stale high samples
  assign flush = (phase == PH_LOW);

  scl_in_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_STAGES (FILT_STAGES)
  ) u_filt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .flush_i     (flush),
    .line_i      (scl_i),
    .seen_high_o (seen_high)
  );

  scl_phase_fsm #(
    .CNT_W      (CNT_W),
    .HOLD_EXTRA (HOLD_EXTRA)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .en_i        (en_i),
    .hcnt_i      (hcnt_sel),
    .lcnt_i      (lcnt_sel),
    .seen_high_i (seen_high),
    .phase_o     (phase)
  );

  assign scl_drive_low_o = (phase == PH_LOW);
  assign low_phase_o     = (phase == PH_LOW);
  assign high_phase_o    = (phase == PH_WAIT) || (phase == PH_COUNT);

  AST_RELEASED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_i |=> (!scl_drive_low_o && !high_phase_o && !low_phase_o)); // R1

  AST_FLAGS_FOLLOW_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en_i |=> (high_phase_o || low_phase_o)); // R8

endmodule

// File: tb/scl_wave_gen_tb_top.sv
module scl_wave_gen_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             en;
  logic             mode;
  logic [CNT_W-1:0] sh, sl, fh, fl;
  logic             drv, hph, lph;
  int               hold_cnt = 0;
  int               stretch_req = 0;
  wire              scl_line = !drv && (hold_cnt == 0);

  scl_wave_gen #(.CNT_W(CNT_W)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .en_i            (en),
    .mode_i          (mode),
    .std_hcnt_i      (sh),
    .std_lcnt_i      (sl),
    .fast_hcnt_i     (fh),
    .fast_lcnt_i     (fl),
    .scl_i           (scl_line),
    .scl_drive_low_o (drv),
    .high_phase_o    (hph),
    .low_phase_o     (lph)
  );

  typedef enum int {M_IDLE, M_HIGH, M_LOW} mph_e;
  mph_e  mph = M_IDLE;
  int    left = 0;
  string cur_req = "R1";
  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    done = 0;

  function automatic int hsel();
    return mode ? int'(fh) : int'(sh);
  endfunction
  function automatic int lsel();
    return mode ? int'(fl) : int'(sl);
  endfunction

  // behavioural reference: phase plus cycles remaining
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph = M_IDLE;
      left = 0;
      hold_cnt <= 0;
    end else begin
      if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
      if (!en) begin
        mph = M_IDLE;
        left = 0;
      end else begin
        case (mph)
          M_IDLE: begin
            mph = M_HIGH;
            left = hsel() + 3;
          end
          M_HIGH: begin
            left--;
            if (left == 0) begin
              mph = M_LOW;
              left = lsel() + 1;
            end
          end
          default: begin
            left--;
            if (left == 0) begin
              mph = M_HIGH;
              left = hsel() + 8 + stretch_req;
              hold_cnt <= stretch_req;
            end
          end
        endcase
      end
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      logic [2:0] act, exp;
      act = {drv, hph, lph};
      exp = {mph == M_LOW, mph == M_HIGH, mph == M_LOW};
      checks++;
      if (act !== exp) begin
        fails++;
        $display("FAIL %s t=%0t {drive,high,low} actual=%b expected=%b",
                 cur_req, $time, act, exp);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ph(mph_e p, int lim);
    for (int i = 0; i < lim; i++) begin
      if (mph == p) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b1; en = 1'b0; mode = 1'b0;
    sh = 16'd4; sl = 16'd5; fh = 16'd2; fl = 16'd1;
    #2 rst_n = 1'b0;
    cur_req = "R1";          // reset state
    run(4);
    rst_n = 1'b1;
    run(6);

    cur_req = "R2"; en = 1'b1; run(8);    // first high = 4+3
    cur_req = "R3"; run(10);
    cur_req = "R4"; run(40);              // high = 4+8, low = 5+1
    cur_req = "R6"; mode = 1'b1; run(40); // fast pair
    cur_req = "R3"; fl = 16'd0; fh = 16'd0; run(30); // low of one cycle
    cur_req = "R5"; stretch_req = 3; run(40);
    stretch_req = 9; run(60);
    stretch_req = 0;

    cur_req = "R7";
    for (int i = 0; i < 240; i++) begin
      if (i % 3 == 0) begin
        sh   = CNT_W'($urandom_range(0, 12));
        sl   = CNT_W'($urandom_range(0, 12));
        fh   = CNT_W'($urandom_range(0, 6));
        fl   = CNT_W'($urandom_range(0, 6));
        mode = 1'($urandom_range(0, 1));
      end
      run(1);
    end

    cur_req = "R8"; sh = 16'd20; sl = 16'd30; mode = 1'b0; run(150);

    cur_req = "R9";
    wait_ph(M_LOW, 200); run(2); en = 1'b0; run(6);
    en = 1'b1; run(12);
    wait_ph(M_LOW, 200); wait_ph(M_HIGH, 200); run(1); en = 1'b0; run(5);
    en = 1'b1; run(30);

    cur_req = "R1"; en = 1'b0; run(3);
    sh = 16'd1; sl = 16'd2; mode = 1'b1; fh = 16'd7; run(4);
    mode = 1'b0; run(10);

    finish_run();
  end

endmodule